// File: doc/BRIEF.md
# Four-pin configurable I/O port with level readback

The block owns a small general-purpose pin port. One 8-bit control register sets each pin. Each pin takes one bit from the upper nibble, the pull-up select, where 0 turns the pull-up on. It takes one bit from the lower nibble, the level select. From these two bits the block derives two pad controls: a low-side driver enable and a pull-up enable. A pin can therefore be driven low, pulled high, or left floating. No pad is ever actively driven high. A logic 1 comes from the pull-up alone, so a pin that an external device holds low is never in contention with a high driver.

A second register is read-only and reports the pin levels. For a pin that the block is driving or pulling, the bit returns the level setting. For a floating pin, the bit returns the external level after that level has passed through a two-stage synchronizer. Both registers are decoded at two fixed addresses on a simple internal bus. The bus has a one-cycle write strobe and a combinational read data path.

Top module: `gpio_port`

## Requirements
- R1: After reset the control register reads 0Fh at address F6h, and every pin has its pull-up enabled and its low driver off.
- R2: A write at address F6h loads all 8 bits of the control register. From the next clock edge the register reads back the written value at F6h.
- R3: For pin i, let the pull-up select be control bit 4+i and the level select be control bit i. The select pair 00 gives drive_low=1 and pullup_en=1. The pair 01 gives drive_low=0 and pullup_en=1. The pair 10 gives drive_low=1 and pullup_en=0. The pair 11 gives drive_low=0 and pullup_en=0, which is high impedance.
- R4: A read at address F7h returns the level select of pin i in bit i for every pin whose select pair is not 11.
- R5: For a pin whose select pair is 11, bit i of address F7h returns the level of pin_in[i] as sampled two clock edges earlier. A change on pin_in first shows up after the second rising edge.
- R6: Bits 7 to 4 of a read at address F7h are always 0.
- R7: A write at address F7h leaves the control register and the pad outputs unchanged.
- R8: A write at any address other than F6h has no effect, and a read at any address other than F6h or F7h returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address for both read and write |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 4 | Pin levels from the pads, asynchronous |
| pad_drive_low | output | 4 | Per-pin enable of the low-side driver |
| pad_pullup_en | output | 4 | Per-pin enable of the internal pull-up |

## Verification
The case that is hardest to reach from the ports is a floating pin whose readback has to follow an external level through the synchronizer. A pin floats only in the 11 code. Readback from the other codes never depends on pin_in, so a wrong select between setting and external level shows up only when the two disagree. The bench sweeps every control value against every pin_in pattern, so each pin meets both the agreeing and the disagreeing case in all four codes. It also samples one cycle after a pin_in change to catch a wrong synchronizer depth.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   // Per-pin pad control produced from one select pair.
   typedef struct packed {
      logic drive_low;
      logic pullup_en;
      logic floating;
   } pad_ctl_t;

   // Decode a select pair: pull = 0 turns on the pull-up, lvl = 0 turns on the low driver.
   function automatic pad_ctl_t decode_pair(input logic pull, input logic lvl);
      pad_ctl_t c;
      c.drive_low = ~lvl;
      c.pullup_en = ~pull;
      c.floating  = pull & lvl;
      return c;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("gpio_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_pkg::*;
(
   input  logic pull_sel,
   input  logic level_sel,
   input  logic pin_sync,
   output logic drive_low,
   output logic pullup_en,
   output logic state_bit
);
   pad_ctl_t ctl;

   always_comb begin
      ctl       = decode_pair(pull_sel, level_sel);
      drive_low = ctl.drive_low;
      pullup_en = ctl.pullup_en;
      state_bit = ctl.floating ? pin_sync : level_sel;
   end
endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hF6,
   parameter logic [DATA_W-1:0] RST_VAL   = 'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] ctrl_q
);
   logic hit;
   assign hit = bus_we && (bus_addr == CTRL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctrl_q <= RST_VAL;
      else if (hit) ctrl_q <= bus_wdata;
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int NPINS       = 4,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hF6,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'hF7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pad_drive_low,
   output logic [NPINS-1:0]  pad_pullup_en
);
   localparam int CTRL_BITS = 2 * NPINS;
   localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'({NPINS{1'b1}});

   generate
      if (CTRL_BITS > DATA_W) begin : g_bad_width
         $error("gpio_port: 2*NPINS must fit in DATA_W");
      end
      if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("gpio_port: register addresses must differ");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;
   logic [NPINS-1:0]  pin_sync;
   logic [NPINS-1:0]  state_bits;

   gpio_ctrl_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .RST_VAL(CTRL_RST)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .ctrl_q(ctrl_q)
   );

   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   genvar i;
   generate
      for (i = 0; i < NPINS; i++) begin : g_pin
         gpio_pin_cell u_cell (
            .pull_sel (ctrl_q[NPINS+i]),
            .level_sel(ctrl_q[i]),
            .pin_sync (pin_sync[i]),
            .drive_low(pad_drive_low[i]),
            .pullup_en(pad_pullup_en[i]),
            .state_bit(state_bits[i])
         );
      end
   endgenerate

   always_comb begin
      if (bus_addr == CTRL_ADDR)      bus_rdata = ctrl_q;
      else if (bus_addr == STAT_ADDR) bus_rdata = DATA_W'(state_bits);
      else                            bus_rdata = '0;
   end
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
   parameter int NPINS       = 4,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hF6,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'hF7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPINS-1:0]  pin_in,
   input logic [NPINS-1:0]  pad_drive_low,
   input logic [NPINS-1:0]  pad_pullup_en
);
   logic [NPINS-1:0] floating;
   assign floating = ~pad_drive_low & ~pad_pullup_en;

   // History of pin_in, one entry per synchronizer stage, plus an age counter.
   logic [NPINS-1:0] hist [SYNC_STAGES];
   logic [3:0]       age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age <= '0;
         for (int k = 0; k < SYNC_STAGES; k++) hist[k] <= '0;
      end else begin
         if (age != 4'hF) age <= age + 4'd1;
         hist[0] <= pin_in;
         for (int k = 1; k < SYNC_STAGES; k++) hist[k] <= hist[k-1];
      end
   end

   assert_reset_pads_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_drive_low == '0) && (pad_pullup_en == '1));

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == CTRL_ADDR) |=>
         (pad_drive_low == ~$past(bus_wdata[NPINS-1:0])) &&
         (pad_pullup_en == ~$past(bus_wdata[2*NPINS-1:NPINS])));

   assert_stat_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == STAT_ADDR) |=> $stable(pad_drive_low) && $stable(pad_pullup_en));

   assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == STAT_ADDR) |-> (bus_rdata[DATA_W-1:NPINS] == '0));

   assert_driven_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == STAT_ADDR) |->
         (((bus_rdata[NPINS-1:0] ^ ~pad_drive_low) & ~floating) == '0));

   assert_float_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == STAT_ADDR && age >= 4'(SYNC_STAGES)) |->
         (((bus_rdata[NPINS-1:0] ^ hist[SYNC_STAGES-1]) & floating) == '0));

   assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != CTRL_ADDR && bus_addr != STAT_ADDR) |-> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_checker #(
   .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
   .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_checker (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
   .pad_drive_low(pad_drive_low), .pad_pullup_en(pad_pullup_en)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [3:0] pin_in = 4'h0;
   logic [3:0] pad_drive_low;
   logic [3:0] pad_pullup_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_drive_low(pad_drive_low), .pad_pullup_en(pad_pullup_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   // Inputs change at the falling edge; results are sampled at a later falling edge.
   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   function automatic logic [3:0] exp_state(input logic [7:0] c, input logic [3:0] p);
      logic [3:0] fl;
      fl = c[7:4] & c[3:0];
      return (fl & p) | (~fl & c[3:0]);
   endfunction

   task automatic read_at(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      read_at(8'hF6, rd);
      check("R1", rd, 8'h0F);
      check("R1", {4'h0, pad_drive_low}, 8'h00);
      check("R1", {4'h0, pad_pullup_en}, 8'h0F);

      // Exhaustive sweep over control values and pin patterns
      for (int v = 0; v < 256; v++) begin
         bus_write(8'hF6, 8'(v));
         read_at(8'hF6, rd);
         check("R2", rd, 8'(v));
         check("R3", {4'h0, pad_drive_low}, {4'h0, ~v[3:0]});
         check("R3", {4'h0, pad_pullup_en}, {4'h0, ~v[7:4]});
         for (int p = 0; p < 16; p++) begin
            pin_in = 4'(p);
            @(negedge clk);
            @(negedge clk);
            read_at(8'hF7, rd);
            check("R6", {4'h0, rd[7:4]}, 8'h00);
            check((v[7:4] & v[3:0]) != 0 ? "R5" : "R4", {4'h0, rd[3:0]},
                  {4'h0, exp_state(8'(v), 4'(p))});
         end
      end

      // R5 latency: all pins floating, pin step seen only after the second edge
      bus_write(8'hF6, 8'hFF);
      pin_in = 4'h0;
      repeat (3) @(negedge clk);
      pin_in = 4'hA;
      @(negedge clk);
      read_at(8'hF7, rd);
      check("R5", rd, 8'h00);
      @(negedge clk);
      read_at(8'hF7, rd);
      check("R5", rd, 8'h0A);

      // R7 writes to the state address are ignored
      bus_write(8'hF6, 8'h5A);
      bus_write(8'hF7, 8'hA5);
      read_at(8'hF6, rd);
      check("R7", rd, 8'h5A);
      check("R7", {4'h0, pad_drive_low}, 8'h05);
      check("R7", {4'h0, pad_pullup_en}, 8'h0A);

      // R8 writes elsewhere ignored, unmapped reads return zero
      bus_write(8'h00, 8'h33);
      bus_write(8'hF5, 8'h33);
      bus_write(8'hF8, 8'h33);
      read_at(8'hF6, rd);
      check("R8", rd, 8'h5A);
      read_at(8'h00, rd);
      check("R8", rd, 8'h00);
      read_at(8'hFF, rd);
      check("R8", rd, 8'h00);
      read_at(8'h40, rd);
      check("R8", rd, 8'h00);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule